// File: doc/BRIEF.md
# First-Fault Gather Load Sequencer

This block performs a predicated gather load for a vector unit, one element at a time, and keeps a first-fault predicate alongside the result. On a start pulse it captures a governing predicate, a table of per-element addresses and an element size. It then walks the elements in ascending order and requests one memory access for each active element. Each response carries read data and a fault flag. Inactive elements issue no access.

Only a fault on the first active element becomes a real, reported fault. A fault on any later active element is swallowed. The load then stops, and the first-fault predicate is cleared for that element and every element above it. Software can read that predicate to find out how far the load got, and continue a loop from there. Loaded data lands in the byte lanes of the element. Lanes that were never loaded read as zero.

Top module: `ff_gather_load`

## Requirements
- R1: After reset, `busy`, `done`, `faultTaken` and `memReq` are low, and `ffrOut` and `dataOut` are all zero.
- R2: `esizeIn` encodes the element size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. With VBYTES vector bytes there are VBYTES>>esizeIn elements. Element i is active when `predIn` bit (i<<esizeIn) is set. Its address is address slot i of `addrIn` (bits i*ADDR_W and up). Its data occupies bytes i<<esizeIn up to (i+1)<<esizeIn of `dataOut`, taken from the low bytes of `memRdata`.
- R3: Requests are issued strictly in ascending element order, and only for active elements. `memSize` carries the captured element size.
- R4: When no access faults, every active element is loaded, inactive element data is zero, and `ffrOut` equals the initial mask: bit b is set exactly when b is a multiple of the element byte size.
- R5: A fault on the first active element pulses `faultTaken` together with `done`. `ffrOut` stays at the initial mask and `dataOut` stays all zero.
- R6: A fault on a later active element is not reported. `faultTaken` stays low, `ffrOut` bits at and above that element's lowest byte are cleared, and the elements loaded before it keep their data.
- R7: After any fault, no further request is issued before the next start.
- R8: `done` is a single-cycle pulse that ends each operation. A `start` pulse while `busy` is high is ignored.
- R9: With an empty predicate, the operation completes with no request, no fault and `ffrOut` equal to the initial mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| esizeIn | input | 2 | Element size code |
| predIn | input | VBYTES | Governing predicate, one bit per byte |
| addrIn | input | VBYTES*ADDR_W | Per-element addresses, slot i at bits i*ADDR_W |
| memReq | output | 1 | Memory request valid, held until acknowledged |
| memAddr | output | ADDR_W | Request address |
| memSize | output | 2 | Request element size code |
| memAck | input | 1 | Response valid for the current request |
| memRdata | input | 64 | Response data, element in the low bytes |
| memFault | input | 1 | Response faulted |
| dataOut | output | VBYTES*8 | Loaded vector |
| ffrOut | output | VBYTES | First-fault predicate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| faultTaken | output | 1 | Real fault, valid with done |

## Verification
The bench aims at the boundary between a real fault and a suppressed one. It makes the first active element fault when it is not element zero, so a design that counted from lane zero instead of from the first active element would swallow a real fault. Suppressed faults are placed mid-vector at both the smallest and the largest element size. A wrong clearing boundary or a wrong element-to-byte mapping would leave stray predicate bits, and a design that kept issuing after the fault would show extra requests in the logged address sequence. A fault address placed on an inactive element, a slow memory that stalls the acknowledge, an empty predicate, and a start pulse arriving mid-operation check in turn for requests from masked lanes, a lost handshake, a hang with no active lanes, and a restart that corrupts the operation in flight.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  // Strobes from the sequencer to the datapath, valid for one cycle each
  typedef struct packed {
    logic init;       // capture operands, preset predicate, clear data
    logic step;       // advance to the next element
    logic writeLane;  // store response data into the current element
    logic clearFrom;  // clear predicate from current element upward
    logic finish;     // operation ends this cycle
    logic fault;      // real fault on the first active element
  } ffgStrobe_t;

  localparam int ESIZE_W = 2;
  localparam int MEM_DATA_W = 64;
endpackage

// File: rtl/ffg_datapath.sv
module ffg_datapath
  import ffg_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ffgStrobe_t               s,
  input  logic [IDX_W-1:0]         idx,
  input  logic [VBYTES-1:0]        startPred,
  input  logic [ESIZE_W-1:0]       startEsize,
  input  logic [VBYTES*ADDR_W-1:0] startAddr,
  input  logic [MEM_DATA_W-1:0]    memRdata,
  output logic                     laneInRange,
  output logic                     laneActive,
  output logic [ADDR_W-1:0]        curAddr,
  output logic [ESIZE_W-1:0]       curEsize,
  output logic [VBYTES*8-1:0]      dataOut,
  output logic [VBYTES-1:0]        ffrOut
);
  localparam int BIDX_W = $clog2(VBYTES);
  localparam int DATA_W = VBYTES * 8;

  logic [VBYTES-1:0]  predR;
  logic [ESIZE_W-1:0] esizeR;
  logic [ADDR_W-1:0]  addrR [VBYTES];
  logic [VBYTES-1:0]  ffrR;
  logic [7:0]         dataB [VBYTES];

  logic [IDX_W-1:0]   numElems;
  logic [IDX_W-1:0]   bytePos;
  logic [BIDX_W-1:0]  bytePosLow;
  logic [8:0]         szMask;
  logic [VBYTES-1:0]  wrBytes;
  logic [VBYTES-1:0]  keepMask;
  logic [VBYTES-1:0]  initMask;
  logic [DATA_W-1:0]  alignedData;

  always_comb begin
    numElems    = IDX_W'(VBYTES) >> esizeR;
    bytePos     = idx << esizeR;
    bytePosLow  = bytePos[BIDX_W-1:0];
    laneInRange = idx < numElems;
    laneActive  = laneInRange && predR[bytePosLow];
    curAddr     = addrR[idx[BIDX_W-1:0]];
    curEsize    = esizeR;
    szMask      = (9'd1 << (4'd1 << esizeR)) - 9'd1;
    wrBytes     = VBYTES'(szMask) << bytePosLow;
    keepMask    = ~({VBYTES{1'b1}} << bytePosLow);
    alignedData = DATA_W'(memRdata) << {bytePosLow, 3'b000};
    for (int b = 0; b < VBYTES; b++)
      initMask[b] = ((b & ((1 << startEsize) - 1)) == 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predR  <= '0;
      esizeR <= '0;
      ffrR   <= '0;
      for (int i = 0; i < VBYTES; i++) addrR[i] <= '0;
    end else if (s.init) begin
      predR  <= startPred;
      esizeR <= startEsize;
      ffrR   <= initMask;
      for (int i = 0; i < VBYTES; i++) addrR[i] <= startAddr[i*ADDR_W +: ADDR_W];
    end else if (s.clearFrom) begin
      ffrR <= ffrR & keepMask;
    end
  end

  // One register byte per vector byte lane
  for (genvar b = 0; b < VBYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        dataB[b] <= '0;
      else if (s.init)                  dataB[b] <= '0;
      else if (s.writeLane && wrBytes[b]) dataB[b] <= alignedData[b*8 +: 8];
    end
    assign dataOut[b*8 +: 8] = dataB[b];
  end

  assign ffrOut = ffrR;

  // R6: outside of an init, predicate bits can only be cleared, never set
  p_ffr_monotone_r6: assert property (@(posedge clk) disable iff (!rstN)
    !s.init |=> ((ffrR & ~$past(ffrR)) == '0));

  // R5: a real fault leaves the predicate untouched
  p_fault_keeps_ffr_r5: assert property (@(posedge clk) disable iff (!rstN)
    s.fault |=> (ffrR == $past(ffrR)));
endmodule

// File: rtl/ffg_ctrl.sv
module ffg_ctrl
  import ffg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             laneInRange,
  input  logic             laneActive,
  input  logic             memAck,
  input  logic             memFault,
  output ffgStrobe_t       s,
  output logic [IDX_W-1:0] idx,
  output logic             memReq,
  output logic             busy,
  output logic             done,
  output logic             faultTaken
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t stateR;
  logic   firstPending;

  always_comb begin
    s      = '0;
    memReq = 1'b0;
    if (stateR == S_IDLE) begin
      s.init = start;
    end else if (!laneInRange) begin
      s.finish = 1'b1;
    end else if (!laneActive) begin
      s.step = 1'b1;
    end else begin
      memReq = 1'b1;
      if (memAck) begin
        if (memFault) begin
          s.finish    = 1'b1;
          s.fault     = firstPending;
          s.clearFrom = !firstPending;
        end else begin
          s.writeLane = 1'b1;
          s.step      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR       <= S_IDLE;
      idx          <= '0;
      firstPending <= 1'b0;
      done         <= 1'b0;
      faultTaken   <= 1'b0;
    end else begin
      done       <= s.finish;
      faultTaken <= s.fault;
      if (s.init) begin
        stateR       <= S_RUN;
        idx          <= '0;
        firstPending <= 1'b1;
      end else begin
        if (s.step)      idx <= idx + 1'b1;
        if (s.writeLane) firstPending <= 1'b0;
        if (s.finish)    stateR <= S_IDLE;
      end
    end
  end

  assign busy = (stateR == S_RUN);

  // R8: done never lasts two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: no request in the cycle the operation reports its end
  p_no_req_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R3: a successful access moves to exactly the next element
  p_ascending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !memFault) |=> (idx == IDX_W'($past(idx) + 1'b1)));

  // R5: a reported fault always arrives with done
  p_fault_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultTaken |-> done);
endmodule

// File: rtl/ff_gather_load.sv
module ff_gather_load
  import ffg_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [1:0]               esizeIn,
  input  logic [VBYTES-1:0]        predIn,
  input  logic [VBYTES*ADDR_W-1:0] addrIn,
  output logic                     memReq,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [1:0]               memSize,
  input  logic                     memAck,
  input  logic [63:0]              memRdata,
  input  logic                     memFault,
  output logic [VBYTES*8-1:0]      dataOut,
  output logic [VBYTES-1:0]        ffrOut,
  output logic                     busy,
  output logic                     done,
  output logic                     faultTaken
);
  localparam int IDX_W = $clog2(VBYTES) + 1;

  ffgStrobe_t       strobes;
  logic [IDX_W-1:0] idx;
  logic             laneInRange;
  logic             laneActive;

  ffg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .laneInRange(laneInRange),
    .laneActive (laneActive),
    .memAck     (memAck),
    .memFault   (memFault),
    .s          (strobes),
    .idx        (idx),
    .memReq     (memReq),
    .busy       (busy),
    .done       (done),
    .faultTaken (faultTaken)
  );

  ffg_datapath #(.VBYTES(VBYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .s          (strobes),
    .idx        (idx),
    .startPred  (predIn),
    .startEsize (esizeIn),
    .startAddr  (addrIn),
    .memRdata   (memRdata),
    .laneInRange(laneInRange),
    .laneActive (laneActive),
    .curAddr    (memAddr),
    .curEsize   (memSize),
    .dataOut    (dataOut),
    .ffrOut     (ffrOut)
  );
endmodule

// File: tb/ff_gather_load_bench.sv
module ff_gather_load_bench;
  localparam int VB = 16;
  localparam int AW = 32;
  localparam logic [AW-1:0] NOFAULT = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] esizeIn = '0;
  logic [VB-1:0] predIn = '0;
  logic [VB*AW-1:0] addrIn;
  logic memReq, busy, done, faultTaken;
  logic [AW-1:0] memAddr;
  logic [1:0] memSize;
  logic memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic memFault = 1'b0;
  logic [VB*8-1:0] dataOut;
  logic [VB-1:0] ffrOut;

  int testCount = 0;
  int failCount = 0;
  logic [AW-1:0] faultA = NOFAULT, faultB = NOFAULT;
  bit slowMem = 0;
  int reqCnt = 0;
  logic [AW-1:0] reqLog [VB];
  logic [1:0] sizeLog [VB];
  int phase = 0;

  logic [VB*8-1:0] expData;
  logic [VB-1:0] expFfr;
  logic expFault;
  int expCnt;
  logic [AW-1:0] expReq [VB];
  logic gotFault;

  always #2.5 clk = ~clk;

  ff_gather_load #(.VBYTES(VB), .ADDR_W(AW)) u_ff_gather_load (
    .clk(clk), .rstN(rstN), .start(start), .esizeIn(esizeIn), .predIn(predIn),
    .addrIn(addrIn), .memReq(memReq), .memAddr(memAddr), .memSize(memSize),
    .memAck(memAck), .memRdata(memRdata), .memFault(memFault),
    .dataOut(dataOut), .ffrOut(ffrOut), .busy(busy), .done(done),
    .faultTaken(faultTaken));

  function automatic logic [AW-1:0] laneAddr(int i);
    return 32'h0000_2000 + AW'(i) * 32'h48;
  endfunction

  function automatic logic [63:0] memData(logic [AW-1:0] a);
    return {a ^ 32'hC0DE_0000, ~a};
  endfunction

  function automatic bit isFault(logic [AW-1:0] a);
    return (a == faultA) || (a == faultB);
  endfunction

  // Memory responder: answers at the falling edge, logs each accepted request
  initial begin
    forever begin
      @(negedge clk);
      phase++;
      if (memReq && (!slowMem || phase[0])) begin
        memAck   = 1'b1;
        memRdata = memData(memAddr);
        memFault = isFault(memAddr);
        if (reqCnt < VB) begin
          reqLog[reqCnt]  = memAddr;
          sizeLog[reqCnt] = memSize;
        end
        reqCnt++;
      end else begin
        memAck   = 1'b0;
        memFault = 1'b0;
        memRdata = '0;
      end
    end
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected result from the requirements
  task automatic model(logic [VB-1:0] pred, logic [1:0] es);
    int esz = 1 << es;
    int n = VB >> es;
    bit first = 1;
    expData = '0;
    expFault = 0;
    expCnt = 0;
    for (int b = 0; b < VB; b++) expFfr[b] = (b % esz) == 0;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      if (!pred[i*esz]) continue;
      a = laneAddr(i);
      expReq[expCnt] = a;
      expCnt++;
      if (isFault(a)) begin
        if (first) expFault = 1;
        else for (int b = i*esz; b < VB; b++) expFfr[b] = 1'b0;
        break;
      end
      for (int k = 0; k < esz; k++) expData[(i*esz+k)*8 +: 8] = memData(a) >> (8*k);
      first = 0;
    end
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, 128'(done), 128'(1));
    gotFault = faultTaken;
  endtask

  task automatic pulseStart(logic [VB-1:0] pred, logic [1:0] es);
    @(negedge clk);
    reqCnt = 0;
    predIn = pred;
    esizeIn = es;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCase(string req, logic [VB-1:0] pred, logic [1:0] es,
                         logic [AW-1:0] fa, logic [AW-1:0] fb, bit slow);
    faultA = fa;
    faultB = fb;
    slowMem = slow;
    pulseStart(pred, es);
    waitDone(req);
    model(pred, es);
    check({req, " faultTaken"}, 128'(gotFault), 128'(expFault));
    check({req, " ffrOut"}, 128'(ffrOut), 128'(expFfr));
    check({req, " dataOut"}, 128'(dataOut), 128'(expData));
    check({req, " R3/R7 request count"}, 128'(reqCnt), 128'(expCnt));
    for (int i = 0; i < expCnt && i < VB; i++) begin
      check({req, " R3 request order"}, 128'(reqLog[i]), 128'(expReq[i]));
      check({req, " R3 request size"}, 128'(sizeLog[i]), 128'(es));
    end
    @(negedge clk);
    check({req, " R8 done one cycle"}, 128'(done), 128'(0));
  endtask

  task automatic tReset();
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 faultTaken", 128'(faultTaken), 128'(0));
    check("R1 memReq", 128'(memReq), 128'(0));
    check("R1 ffrOut", 128'(ffrOut), 128'(0));
    check("R1 dataOut", 128'(dataOut), 128'(0));
  endtask

  task automatic tBusyStart();
    int extra = 0;
    faultA = NOFAULT;
    faultB = NOFAULT;
    slowMem = 0;
    pulseStart(16'hFFFF, 2'd0);
    repeat (3) @(negedge clk);
    check("R8 busy during run", 128'(busy), 128'(1));
    predIn = 16'h0000;
    esizeIn = 2'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R8 restart ignored");
    model(16'hFFFF, 2'd0);
    check("R8 restart ignored ffrOut", 128'(ffrOut), 128'(expFfr));
    check("R8 restart ignored dataOut", 128'(dataOut), 128'(expData));
    check("R8 restart ignored count", 128'(reqCnt), 128'(16));
    repeat (20) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R8 single done pulse", 128'(extra), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < VB; i++) addrIn[i*AW +: AW] = laneAddr(i);
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    runCase("R4 all active bytes", 16'hFFFF, 2'd0, NOFAULT, NOFAULT, 0);
    runCase("R2 halfwords slow mem", 16'h3333, 2'd1, NOFAULT, NOFAULT, 1);
    runCase("R2 words", 16'h0111, 2'd2, NOFAULT, NOFAULT, 0);
    runCase("R2 doublewords", 16'h0101, 2'd3, NOFAULT, NOFAULT, 0);
    runCase("R3 sparse bytes", 16'hA5C0, 2'd0, NOFAULT, NOFAULT, 1);
    runCase("R3 fault on inactive lane", 16'h0005, 2'd1, laneAddr(3), NOFAULT, 0);
    runCase("R5 first active faults", 16'h1110, 2'd2, laneAddr(1), NOFAULT, 0);
    runCase("R6 later fault bytes", 16'hFFFF, 2'd0, laneAddr(5), laneAddr(9), 0);
    runCase("R6 later fault doublewords", 16'h0101, 2'd3, laneAddr(1), NOFAULT, 1);
    runCase("R7 stop after suppressed fault", 16'h5555, 2'd1, laneAddr(2), laneAddr(4), 0);
    runCase("R9 empty predicate", 16'h0000, 2'd2, NOFAULT, NOFAULT, 0);
    tBusyStart();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule